// File: doc/BRIEF.md
# Tagged General-Purpose Register File

This block is a register file in which every register carries hidden metadata next to its data word. The metadata consists of a zero flag, a presence flag, a validated-pointer flag with the cached access rights, and a validated-code-address flag. The zero flags are recomputed on every write, so together they work as a status register spread across the file. The presence flags let a background save/restore engine take registers out of the file during a context switch and bring them back later. The pointer and code tags record that an address translation check has already succeeded for the value now held, so a later load, store or jump can skip that check.

All tags are advisory and can be dropped at any time. A write of new data, a context switch or a translation flush clears them. After that, the next use pays a re-check and gets the same result. A translation-check unit sets the tags through an update port. It must return the write-sequence bit it read when it started the check, and an update whose sequence bit is stale is dropped. Store address checks run against the cached rights. A store through a validated base register whose rights forbid writing is flagged as a fault and is not issued.

Top module: `tagged_regfile`

## Requirements
- R1: A write to register k (k not 0) is returned by both read ports from the next cycle on. Register 0 always reads as data 0 with its zero flag at 1, and writes and tag updates addressed to it have no effect.
- R2: The zero flag of a register is 1 exactly when the last data written to it was all zeros. It is recomputed on every write.
- R3: A read of the register being written in the same cycle returns the new data, its new zero flag and its new sequence bit, with presence 1 and both pointer and code tags 0.
- R4: An evict request clears the presence flag of its register (not register 0). A write sets the presence flag again. If an evict and a write address the same register in the same cycle, the write wins.
- R5: An accepted tag update with code-select 0 sets the pointer tag and loads the 2-bit rights, where bit 1 = store permitted and bit 0 = load permitted. With code-select 1 it sets only the code tag.
- R6: Each write toggles the register's sequence bit. An update is dropped if its sequence bit differs from the register's, if it targets register 0, or if a write hits the same register in the same cycle.
- R7: Any write to a register clears its pointer and code tags at the write edge.
- R8: A flush clears every pointer and code tag. A tag update in the same cycle as a flush is dropped.
- R9: For a store request, the fault output is 1 and the issue output is 0 when the base register has its pointer tag set and rights bit 1 at 0. Otherwise issue equals the request and fault is 0. The check applies the same-cycle write bypass of R3.
- R10: After reset, every register holds 0 with zero flag 1, presence 1, sequence bit 0, rights 0, and pointer and code tags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write register index |
| wr_data | input | XLEN | Write data |
| rd0_addr | input | AW | Port 0 register index |
| rd0_data | output | XLEN | Port 0 data |
| rd0_zero | output | 1 | Port 0 zero flag |
| rd0_present | output | 1 | Port 0 presence flag |
| rd0_seq | output | 1 | Port 0 write-sequence bit |
| rd0_ptr_ok | output | 1 | Port 0 validated-pointer tag |
| rd0_rights | output | RW | Port 0 cached rights |
| rd0_code_ok | output | 1 | Port 0 validated-code tag |
| rd1_addr | input | AW | Port 1 register index |
| rd1_data | output | XLEN | Port 1 data |
| rd1_zero | output | 1 | Port 1 zero flag |
| tu_en | input | 1 | Tag update request |
| tu_addr | input | AW | Tag update register index |
| tu_seq | input | 1 | Sequence bit read when the check started |
| tu_code | input | 1 | 1 = set code tag, 0 = set pointer tag and rights |
| tu_rights | input | RW | Rights for a pointer tag |
| tag_flush | input | 1 | Clear all pointer and code tags |
| ev_en | input | 1 | Evict request (clear presence) |
| ev_addr | input | AW | Evict register index |
| st_en | input | 1 | Store request |
| st_base | input | AW | Store base register index |
| st_fault | output | 1 | Store permission fault |
| st_issue | output | 1 | Store may proceed |

## Verification
The bench targets stale tag updates: one that arrives after an intervening write, and one that lands in the same cycle as a write. A design that skips the sequence check would leave a pointer tag on data that was never translated. It also drives a flush and an update in the same cycle, where the wrong priority leaves a tag set after a context switch. The remaining cases are the register-0 tag update and store checks through read-only and writable bases, including a store whose base is rewritten in that same cycle. A design without the write bypass would raise a false fault there, or report stale data and a stale zero flag on the read ports.

// File: rtl/tagged_regfile.sv
module tagged_regfile #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  parameter int RW   = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [AW-1:0]   rd0_addr,
  output logic [XLEN-1:0] rd0_data,
  output logic            rd0_zero,
  output logic            rd0_present,
  output logic            rd0_seq,
  output logic            rd0_ptr_ok,
  output logic [RW-1:0]   rd0_rights,
  output logic            rd0_code_ok,
  input  logic [AW-1:0]   rd1_addr,
  output logic [XLEN-1:0] rd1_data,
  output logic            rd1_zero,
  input  logic            tu_en,
  input  logic [AW-1:0]   tu_addr,
  input  logic            tu_seq,
  input  logic            tu_code,
  input  logic [RW-1:0]   tu_rights,
  input  logic            tag_flush,
  input  logic            ev_en,
  input  logic [AW-1:0]   ev_addr,
  input  logic            st_en,
  input  logic [AW-1:0]   st_base,
  output logic            st_fault,
  output logic            st_issue
);
  localparam int WBIT = 1;

  logic [XLEN-1:0] data [NREG];
  logic [RW-1:0]   rts  [NREG];
  logic [NREG-1:0] zf, pres, seq, ptr, code;

  logic wv, hit0, hit1, hits, tu_ok;
  assign wv    = wr_en && (wr_addr != '0);
  assign hit0  = wv && (wr_addr == rd0_addr);
  assign hit1  = wv && (wr_addr == rd1_addr);
  assign hits  = wv && (wr_addr == st_base);
  assign tu_ok = tu_en && (tu_addr != '0) && (tu_seq == seq[tu_addr])
                 && !(wv && wr_addr == tu_addr) && !tag_flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        data[i] <= '0;
        rts[i]  <= '0;
      end
      zf   <= '1;
      pres <= '1;
      seq  <= '0;
      ptr  <= '0;
      code <= '0;
    end else begin
      if (ev_en && ev_addr != '0) pres[ev_addr] <= 1'b0;
      if (tu_ok) begin
        if (tu_code) code[tu_addr] <= 1'b1;
        else begin
          ptr[tu_addr] <= 1'b1;
          rts[tu_addr] <= tu_rights;
        end
      end
      if (wv) begin
        data[wr_addr] <= wr_data;
        zf[wr_addr]   <= (wr_data == '0);
        pres[wr_addr] <= 1'b1;
        seq[wr_addr]  <= ~seq[wr_addr];
        ptr[wr_addr]  <= 1'b0;
        code[wr_addr] <= 1'b0;
      end
      if (tag_flush) begin
        ptr  <= '0;
        code <= '0;
      end
    end
  end

  assign rd0_data    = hit0 ? wr_data : data[rd0_addr];
  assign rd0_zero    = hit0 ? (wr_data == '0) : zf[rd0_addr];
  assign rd0_present = hit0 | pres[rd0_addr];
  assign rd0_seq     = hit0 ^ seq[rd0_addr];
  assign rd0_ptr_ok  = !hit0 && ptr[rd0_addr];
  assign rd0_rights  = rts[rd0_addr];
  assign rd0_code_ok = !hit0 && code[rd0_addr];

  assign rd1_data = hit1 ? wr_data : data[rd1_addr];
  assign rd1_zero = hit1 ? (wr_data == '0) : zf[rd1_addr];

  assign st_fault = st_en && !hits && ptr[st_base] && !rts[st_base][WBIT];
  assign st_issue = st_en && !st_fault;
endmodule

// File: rtl/tagged_regfile_chk.sv
module tagged_regfile_chk #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  parameter int RW   = 2,
  localparam int AW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [XLEN-1:0] wr_data,
  input logic [AW-1:0]   rd0_addr,
  input logic [XLEN-1:0] rd0_data,
  input logic            rd0_zero,
  input logic            rd0_ptr_ok,
  input logic            rd0_code_ok,
  input logic            tag_flush,
  input logic            st_fault,
  input logic            st_issue
);
  p_r0_const_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_addr == '0) |-> (rd0_data == '0 && rd0_zero));

  p_write_visible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && !(wr_en && wr_addr == rd0_addr)) ##1
    (rd0_addr == $past(wr_addr) && !(wr_en && wr_addr == rd0_addr))
    |-> rd0_data == $past(wr_data));

  p_zero_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_zero == (rd0_data == '0));

  p_write_clears_tags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0) ##1 (rd0_addr == $past(wr_addr))
    |-> !rd0_ptr_ok && !rd0_code_ok);

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tag_flush |=> !rd0_ptr_ok && !rd0_code_ok);

  p_fault_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_fault && st_issue));
endmodule

bind tagged_regfile tagged_regfile_chk #(.NREG(NREG), .XLEN(XLEN), .RW(RW)) u_chk (.*);

// File: tb/tb_tagged_regfile.sv
module tb_tagged_regfile;
  localparam int NREG = 16, XLEN = 32, RW = 2, AW = 4;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, tu_en = 0, tu_seq = 0, tu_code = 0, tag_flush = 0, ev_en = 0, st_en = 0;
  logic [AW-1:0] wr_addr = 0, rd0_addr = 0, rd1_addr = 0, tu_addr = 0, ev_addr = 0, st_base = 0;
  logic [XLEN-1:0] wr_data = 0;
  logic [RW-1:0] tu_rights = 0;
  logic [XLEN-1:0] rd0_data, rd1_data;
  logic rd0_zero, rd0_present, rd0_seq, rd0_ptr_ok, rd0_code_ok, rd1_zero, st_fault, st_issue;
  logic [RW-1:0] rd0_rights;

  always #2.5 clk = ~clk;

  tagged_regfile #(.NREG(NREG), .XLEN(XLEN), .RW(RW)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ck(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic tu(input logic [AW-1:0] a, input logic s, input logic c, input logic [1:0] r);
    tu_en = 1; tu_addr = a; tu_seq = s; tu_code = c; tu_rights = r; tick(); tu_en = 0;
  endtask

  typedef struct packed {
    logic        w;
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] ed;
    logic        ez;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b1, 4'd3, 32'h12, 4'd3, 32'h12, 1'b0},
    '{1'b0, 4'd0, 32'h0,  4'd3, 32'h12, 1'b0},
    '{1'b1, 4'd4, 32'h0,  4'd4, 32'h0,  1'b1},
    '{1'b1, 4'd0, 32'h5,  4'd0, 32'h0,  1'b1},
    '{1'b1, 4'd3, 32'h0,  4'd3, 32'h0,  1'b1},
    '{1'b0, 4'd0, 32'h0,  4'd1, 32'h0,  1'b1},
    '{1'b0, 4'd0, 32'h0,  4'd4, 32'h0,  1'b1}
  };

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic s;
    tick(); tick(); rst_n = 1; tick();

    rd0_addr = 5; #1;
    ck("R10 data", rd0_data, 0);
    ck("R10 zero", rd0_zero, 1);
    ck("R10 present", rd0_present, 1);
    ck("R10 seq", rd0_seq, 0);
    ck("R10 tags", {rd0_ptr_ok, rd0_code_ok, rd0_rights}, 0);

    foreach (VEC[i]) begin
      wr_en = VEC[i].w; wr_addr = VEC[i].wa; wr_data = VEC[i].wd;
      rd0_addr = VEC[i].ra; rd1_addr = VEC[i].ra; #1;
      ck("R1/R3 rd0 data", rd0_data, VEC[i].ed);
      ck("R2 rd0 zero", rd0_zero, VEC[i].ez);
      ck("R1 rd1 data", rd1_data, VEC[i].ed);
      tick(); wr_en = 0;
    end

    // R5, R9 read-only pointer
    wr(6, 32'h1000); rd0_addr = 6; #1; s = rd0_seq;
    ck("R6 seq toggles", s, 1);
    tu(6, s, 0, 2'b01); #1;
    ck("R5 ptr set", rd0_ptr_ok, 1);
    ck("R5 rights", rd0_rights, 2'b01);
    st_en = 1; st_base = 6; #1;
    ck("R9 fault read-only", {st_fault, st_issue}, 2'b10);
    st_en = 0;

    // R9 writable pointer
    wr(7, 32'h2000); rd0_addr = 7; #1; s = rd0_seq;
    tu(7, s, 0, 2'b11);
    st_en = 1; st_base = 7; #1;
    ck("R9 writable issues", {st_fault, st_issue}, 2'b01);

    // R3/R9 same-cycle rewrite of read-only base
    st_base = 6; wr_en = 1; wr_addr = 6; wr_data = 32'h3000; rd0_addr = 6; #1;
    ck("R9 bypass no fault", {st_fault, st_issue}, 2'b01);
    ck("R3 bypass ptr", rd0_ptr_ok, 0);
    tick(); wr_en = 0; st_en = 0; #1;
    ck("R7 ptr cleared", rd0_ptr_ok, 0);

    // R6 stale after intervening write
    wr(8, 32'h40); rd0_addr = 8; #1; s = rd0_seq;
    wr(8, 32'h44);
    tu(8, s, 0, 2'b11); #1;
    ck("R6 stale dropped", rd0_ptr_ok, 0);

    // R6 update same cycle as write
    wr(11, 32'h50); rd0_addr = 11; #1; s = rd0_seq;
    wr_en = 1; wr_addr = 11; wr_data = 32'h54;
    tu(11, s, 0, 2'b11); wr_en = 0; #1;
    ck("R6 same-cycle write wins", rd0_ptr_ok, 0);

    // R5 code tag
    wr(9, 32'h80); rd0_addr = 9; #1; s = rd0_seq;
    tu(9, s, 1, 2'b11); #1;
    ck("R5 code tag", {rd0_code_ok, rd0_ptr_ok}, 2'b10);

    // R8 flush
    tag_flush = 1; tick(); tag_flush = 0; #1;
    ck("R8 code cleared", rd0_code_ok, 0);
    rd0_addr = 7; #1;
    ck("R8 ptr cleared", rd0_ptr_ok, 0);
    s = rd0_seq; tag_flush = 1;
    tu(7, s, 0, 2'b11); tag_flush = 0; #1;
    ck("R8 flush beats update", rd0_ptr_ok, 0);

    // R1 register 0 tags
    rd0_addr = 0; #1; s = rd0_seq;
    tu(0, s, 0, 2'b11); #1;
    ck("R1 r0 no tag", rd0_ptr_ok, 0);

    // R4 presence
    ev_en = 1; ev_addr = 10; tick(); ev_en = 0;
    rd0_addr = 10; #1;
    ck("R4 evict", rd0_present, 0);
    wr(10, 32'h1); #1;
    ck("R4 write restores", rd0_present, 1);
    ev_en = 1; ev_addr = 10; wr_en = 1; wr_addr = 10; wr_data = 32'h2;
    tick(); ev_en = 0; wr_en = 0; #1;
    ck("R4 write beats evict", rd0_present, 1);

    // R3 on port 1
    rd1_addr = 12; wr_en = 1; wr_addr = 12; wr_data = 32'h7; #1;
    ck("R3 rd1 bypass", {rd1_data, 1'b0} | {31'b0, rd1_zero}, {32'h7, 1'b0});
    tick(); wr_en = 0;

    finish_up();
  end
endmodule